// File: doc/BRIEF.md
# Serial Control Register Slave with Autozero Mute Trigger

This block is the control-port front end of a signal-processing chip. It is a two-wire serial slave that answers one fixed 7-bit device address. A write transfer carries a subaddress byte and then any number of data bytes, and those data bytes land in a bank of 8-bit control registers. A read transfer streams a status byte that the surrounding chip supplies. The block samples both bus lines with the system clock, finds start and stop conditions from them, and pulls SDA low through an open-drain enable when it acknowledges or sends a zero.

The subaddress byte does more than select a register. Its top three bits set three flags for the transfer: a test flag, a flag that keeps the existing offset alignment, and an auto-increment flag. Its low five bits are the starting register index.

When a data byte is written to the input-source register and the keep-alignment flag is clear, the block starts a timed autozero alignment. A mute-hold output rises first. One cycle later a busy output covers a fixed window of clock cycles, and the mute-hold output stays high for that whole window. A test-mode output is high only while both the test flag of the latest subaddress and bit 0 of the test register are set.

Top module: `ctl_i2c_regbank`

## Requirements
- R1: The slave responds only to the 7-bit address 7'b1000100, taken from bits 7..1 of the first byte after a start, with bit 0 = 0 for write and 1 for read. It acknowledges by pulling SDA low during the 9th clock. For any other address it keeps SDA released until the next start or stop.
- R2: The subaddress byte is acknowledged and decoded as follows: bit 7 is the test flag, bit 6 is keep-alignment, bit 5 is auto-increment, and bits 4..0 are the start index. The flags hold until the next subaddress byte.
- R3: Each data byte is acknowledged and stored in the register at the current index, which appears as regs_o[8*i+7:8*i]. A byte aimed at an index of NUM_REGS or above is acknowledged and then dropped.
- R4: With auto-increment set, each following data byte goes to the next index, and the index wraps from 31 to 0. With auto-increment clear, every data byte of the transfer goes to the same index.
- R5: A data byte written to the source register (index SRC_IDX = 0) while keep-alignment is clear raises mute_hold_o in the cycle after the write commits. az_busy_o is then high for exactly AZ_CYCLES cycles, and mute_hold_o stays high during all of them.
- R6: With keep-alignment set, a write to the source register updates the register but starts no alignment and raises neither output.
- R7: A read streams status_i MSB first. The byte is captured again at the end of every master acknowledge, so repeated bytes need no new address. A master not-acknowledge releases SDA for the rest of the transfer.
- R8: test_mode_o is high exactly when the test flag of the latest subaddress and bit 0 of register TEST_IDX (17) are both 1.
- R9: After a synchronous active-low reset, every register holds RESET_VALUE (8'hFE), and sda_oe_o, az_busy_o, mute_hold_o and test_mode_o are low.
- R10: A source write that lands during a running alignment restarts the window, so busy stays high continuously until AZ_CYCLES cycles after the latest trigger.
- R11: Writes to any register other than the source register never start an alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad (wired-AND) |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain drive) |
| status_i | input | 8 | Status byte returned on reads; bit 0 is the soft-mute flag |
| regs_o | output | 8*NUM_REGS | Flattened control register bank, register i at bits 8*i+7..8*i |
| test_mode_o | output | 1 | Test mode active |
| az_busy_o | output | 1 | Autozero alignment window running |
| mute_hold_o | output | 1 | Signal path must stay muted |

## Verification
Some properties are checked on every cycle: each committed byte lands in its register, SDA changes only while SCL is low, SDA is never driven after an address mismatch or a master not-acknowledge, and an alignment trigger is always followed by mute. A counter also checks that a busy run never exceeds the window, and that writes with keep-alignment set or to other registers never raise mute. Some behaviour can only be shown by the bench's transfers: the exact busy length of a single trigger and of a retrigger, the index order under auto-increment and its wrap, status bytes that change between successive read bytes, and the test-mode combination across several transfers.

// File: rtl/ctl_i2c_pkg.sv
// Package: shared encodings for the serial control register slave.
// Assumes a 5-bit register index and 8-bit bytes on the bus.
package ctl_i2c_pkg;

    localparam int IDX_W       = 5;
    localparam int BYTE_W      = 8;
    localparam int SUB_TEST    = 7;
    localparam int SUB_KEEP    = 6;
    localparam int SUB_AINC    = 5;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } slv_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
// Module: i2c_line_sync
// Brings SCL and SDA into the clock domain through a synchronizer chain
// and derives clock edges plus start/stop conditions from them.
// Assumes the bus is several times slower than clk. Both lines reset to
// the idle-high level.
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_STAGES-1:0] scl_chain;
    logic [SYNC_STAGES-1:0] sda_chain;
    logic                   scl_q;
    logic                   sda_q;

    // Synchronizer chains, one flop per stage, both lines idle high.
    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        scl_chain[0] <= 1'b1;
                        sda_chain[0] <= 1'b1;
                    end else begin
                        scl_chain[0] <= scl_i;
                        sda_chain[0] <= sda_i;
                    end
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        scl_chain[s] <= 1'b1;
                        sda_chain[s] <= 1'b1;
                    end else begin
                        scl_chain[s] <= scl_chain[s-1];
                        sda_chain[s] <= sda_chain[s-1];
                    end
                end
            end
        end
    endgenerate

    assign scl_s = scl_chain[SYNC_STAGES-1];
    assign sda_s = sda_chain[SYNC_STAGES-1];

    // Previous synchronized values, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Edge and bus-condition decode from the current and previous samples.
    always_comb begin
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/i2c_slave_fsm.sv
// Module: i2c_slave_fsm
// Byte-level slave protocol: address match, subaddress decode, data-byte
// commit strobes, and status transmission on reads.
// Assumes the conditioned edges from i2c_line_sync. SDA changes only after
// a detected SCL fall, so it never moves while SCL is high.
module i2c_slave_fsm
    import ctl_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1000100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] status_i,
    output logic              sda_oe,
    output logic              wr_stb,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sub_test,
    output logic              sub_keep
);

    slv_state_t        state;
    logic [3:0]        cnt;
    logic [BYTE_W-1:0] sh;
    logic [BYTE_W-1:0] tx;
    logic              rw;
    logic              ainc;
    logic              mnack;
    logic [IDX_W-1:0]  idx;

    // Protocol sequencer: bits are shifted in on SCL rise, acknowledges and
    // transmit bits change on SCL fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            sh       <= '0;
            tx       <= '0;
            rw       <= 1'b0;
            ainc     <= 1'b0;
            mnack    <= 1'b0;
            idx      <= '0;
            sda_oe   <= 1'b0;
            wr_stb   <= 1'b0;
            wr_idx   <= '0;
            wr_data  <= '0;
            sub_test <= 1'b0;
            sub_keep <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            if (start_det) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (scl_rise) begin
                if ((state == ST_ADDR || state == ST_SUB || state == ST_WDATA)
                    && cnt < 4'd8) begin
                    sh  <= {sh[BYTE_W-2:0], sda_s};
                    cnt <= cnt + 4'd1;
                end else if (state == ST_RACK) begin
                    mnack <= sda_s;
                end
            end else if (scl_fall) begin
                case (state)
                    ST_ADDR: if (cnt == 4'd8) begin
                        if (sh[7:1] == DEV_ADDR) begin
                            sda_oe <= 1'b1;
                            rw     <= sh[0];
                            state  <= ST_ADDR_ACK;
                        end else begin
                            state  <= ST_IGNORE;
                        end
                    end
                    ST_SUB: if (cnt == 4'd8) begin
                        sub_test <= sh[SUB_TEST];
                        sub_keep <= sh[SUB_KEEP];
                        ainc     <= sh[SUB_AINC];
                        idx      <= sh[IDX_W-1:0];
                        sda_oe   <= 1'b1;
                        state    <= ST_SUB_ACK;
                    end
                    ST_WDATA: if (cnt == 4'd8) begin
                        wr_stb  <= 1'b1;
                        wr_idx  <= idx;
                        wr_data <= sh;
                        sda_oe  <= 1'b1;
                        state   <= ST_WDATA_ACK;
                    end
                    ST_ADDR_ACK: begin
                        if (rw) begin
                            tx     <= status_i;
                            sda_oe <= ~status_i[BYTE_W-1];
                            cnt    <= 4'd1;
                            state  <= ST_RDATA;
                        end else begin
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                            state  <= ST_SUB;
                        end
                    end
                    ST_SUB_ACK: begin
                        sda_oe <= 1'b0;
                        cnt    <= '0;
                        state  <= ST_WDATA;
                    end
                    ST_WDATA_ACK: begin
                        sda_oe <= 1'b0;
                        cnt    <= '0;
                        state  <= ST_WDATA;
                        if (ainc) idx <= idx + 1'b1;
                    end
                    ST_RDATA: begin
                        if (cnt == 4'd8) begin
                            sda_oe <= 1'b0;
                            state  <= ST_RACK;
                        end else begin
                            sda_oe <= ~tx[BYTE_W-2];
                            tx     <= {tx[BYTE_W-2:0], 1'b0};
                            cnt    <= cnt + 4'd1;
                        end
                    end
                    ST_RACK: begin
                        if (mnack) begin
                            sda_oe <= 1'b0;
                            state  <= ST_IGNORE;
                        end else begin
                            tx     <= status_i;
                            sda_oe <= ~status_i[BYTE_W-1];
                            cnt    <= 4'd1;
                            state  <= ST_RDATA;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R1: a transfer that is ignored never drives the data line.
    p_ignore_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> !sda_oe);

    // R1: the drive changes only while SCL is low, except on bus conditions.
    p_sda_moves_scl_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe) && !$past(start_det) && !$past(stop_det)) |-> !scl_s);

    // R3: a commit strobe only follows the data-byte phase.
    p_commit_from_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> ($past(state) == ST_WDATA && state == ST_WDATA_ACK));

    // R7: after a master not-acknowledge the line stays released.
    p_nack_releases_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_RACK && state == ST_IGNORE) |-> !sda_oe);

endmodule

// File: rtl/az_window.sv
// Module: az_window
// Timed autozero alignment window. A trigger arms a one-cycle stage, then
// busy runs for exactly AZ_CYCLES cycles. A new trigger reloads the count.
// Assumes a single-cycle trigger pulse.
module az_window #(
    parameter int AZ_CYCLES = 60000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic busy_o,
    output logic hold_o
);

    localparam int CNT_W = $clog2(AZ_CYCLES + 1);

    logic             arm;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   run_len;

    // Arm stage followed by the down-counting busy window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm    <= 1'b0;
            busy_o <= 1'b0;
            cnt    <= '0;
        end else begin
            arm <= trig_i;
            if (arm) begin
                busy_o <= 1'b1;
                cnt    <= CNT_W'(AZ_CYCLES - 1);
            end else if (busy_o) begin
                if (cnt == '0) busy_o <= 1'b0;
                else           cnt    <= cnt - 1'b1;
            end
        end
    end

    assign hold_o = arm | busy_o;

    // Checker counter: length of the current busy run since its last arm.
    always_ff @(posedge clk) begin
        if (!rst_n)      run_len <= '0;
        else if (arm)    run_len <= '0;
        else if (busy_o) run_len <= run_len + 1'b1;
    end

    // R5: an armed trigger always opens the busy window.
    p_arm_opens_r5: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> busy_o);

    // R5 / R10: no busy run lasts longer than the window after its last trigger.
    p_window_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (run_len < (CNT_W + 1)'(AZ_CYCLES)));

endmodule

// File: rtl/ctl_i2c_regbank.sv
// Module: ctl_i2c_regbank (top)
// Serial control register slave: line conditioning, protocol sequencing,
// the register bank, the test-mode combination and the autozero trigger.
// Assumes NUM_REGS <= 32, and SRC_IDX and TEST_IDX below NUM_REGS.
module ctl_i2c_regbank
    import ctl_i2c_pkg::*;
#(
    parameter int         NUM_REGS    = 18,
    parameter int         SRC_IDX     = 0,
    parameter int         TEST_IDX    = 17,
    parameter int         AZ_CYCLES   = 60000,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEV_ADDR    = 7'b1000100,
    parameter logic [7:0] RESET_VALUE = 8'hFE
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_i,
    input  logic                       sda_i,
    output logic                       sda_oe_o,
    input  logic [BYTE_W-1:0]          status_i,
    output logic [NUM_REGS*BYTE_W-1:0] regs_o,
    output logic                       test_mode_o,
    output logic                       az_busy_o,
    output logic                       mute_hold_o
);

    localparam logic [IDX_W-1:0] SRC_SEL = IDX_W'(SRC_IDX);

    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_stb, sub_test, sub_keep;
    logic [IDX_W-1:0]  wr_idx;
    logic [BYTE_W-1:0] wr_data;
    logic [BYTE_W-1:0] bank [NUM_REGS];
    logic              az_trig;

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_slave_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .status_i  (status_i),
        .sda_oe    (sda_oe_o),
        .wr_stb    (wr_stb),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .sub_test  (sub_test),
        .sub_keep  (sub_keep)
    );

    // Register bank: one storage byte per index, loaded on a matching commit.
    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            always_ff @(posedge clk) begin
                if (!rst_n)                                bank[g] <= RESET_VALUE;
                else if (wr_stb && wr_idx == IDX_W'(g))    bank[g] <= wr_data;
            end
            assign regs_o[g*BYTE_W +: BYTE_W] = bank[g];

            // R3: a committed byte is visible in its register next cycle.
            p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_stb && wr_idx == IDX_W'(g)) |=> (bank[g] == $past(wr_data)));
        end
    endgenerate

    // Test mode needs the subaddress flag and bit 0 of the test register.
    always_comb test_mode_o = sub_test & bank[TEST_IDX][0];

    // Autozero trigger: source register written without keep-alignment.
    always_comb az_trig = wr_stb && (wr_idx == SRC_SEL) && !sub_keep;

    az_window #(.AZ_CYCLES(AZ_CYCLES)) u_az (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_i (az_trig),
        .busy_o (az_busy_o),
        .hold_o (mute_hold_o)
    );

    // R5: a qualifying source write mutes in the following cycle.
    p_src_write_mutes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_idx == SRC_SEL && !sub_keep) |=> mute_hold_o);

    // R6: keep-alignment suppresses the mute when none is running.
    p_keep_no_mute_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_idx == SRC_SEL && sub_keep && !mute_hold_o) |=> !mute_hold_o);

    // R11: other registers never start an alignment.
    p_other_no_mute_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_idx != SRC_SEL && !mute_hold_o) |=> !mute_hold_o);

endmodule

// File: tb/test_ctl_i2c_regbank.sv
`timescale 1ns/1ps
module test_ctl_i2c_regbank;

    localparam int NREG = 18;
    localparam int AZC  = 400;
    localparam int Q    = 8;
    localparam int SRC  = 0;
    localparam int TST  = 17;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic             rst_n;
    logic             m_scl;
    logic             m_low;
    logic [7:0]       status;
    logic             sda_oe;
    logic [NREG*8-1:0] regs;
    logic             test_mode, az_busy, mute_hold;
    wire              sda_line = !(m_low || sda_oe);

    ctl_i2c_regbank #(.NUM_REGS(NREG), .AZ_CYCLES(AZC)) i_ctl_i2c_regbank (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (m_scl),
        .sda_i       (sda_line),
        .sda_oe_o    (sda_oe),
        .status_i    (status),
        .regs_o      (regs),
        .test_mode_o (test_mode),
        .az_busy_o   (az_busy),
        .mute_hold_o (mute_hold)
    );

    int         n_cmp = 0;
    int         n_bad = 0;
    logic [7:0] model [32];
    logic       m_test = 1'b0;
    logic [7:0] wbuf [8];

    // Observation counters, written only here.
    int   busy_cyc = 0, busy_rise = 0, oe_cyc = 0;
    logic busy_d = 1'b0;
    always @(posedge clk) begin
        if (az_busy) busy_cyc++;
        if (az_busy && !busy_d) busy_rise++;
        busy_d = az_busy;
        if (sda_oe) oe_cyc++;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        m_low = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_low = 1'b1; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic i2c_stop();
        m_low = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_low = 1'b0; tick(Q);
    endtask

    task automatic write_byte(input logic [7:0] b, output bit ack, output bit mh);
        for (int i = 7; i >= 0; i--) begin
            m_low = !b[i]; tick(Q);
            m_scl = 1'b1;  tick(2*Q);
            m_scl = 1'b0;  tick(Q);
        end
        m_low = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        ack = !sda_line;
        mh  = mute_hold;
        tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic read_byte(input bit nack, input logic [7:0] next_st,
                             output logic [7:0] b);
        m_low = 1'b0;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            tick(Q);
            m_scl = 1'b1; tick(Q);
            b = {b[6:0], sda_line};
            tick(Q);
            m_scl = 1'b0;
        end
        tick(Q);
        status = next_st;
        m_low = !nack; tick(Q);
        m_scl = 1'b1;  tick(2*Q);
        m_scl = 1'b0;  tick(Q);
        m_low = 1'b0;
    endtask

    task automatic compare_regs(input string req);
        int bad_i = -1;
        for (int i = 0; i < NREG; i++)
            if (regs[i*8 +: 8] !== model[i] && bad_i < 0) bad_i = i;
        if (bad_i < 0) check(1'b1, req, "register bank", 0, 0);
        else check(1'b0, req, $sformatf("register %0d", bad_i),
                   int'(regs[bad_i*8 +: 8]), int'(model[bad_i]));
    endtask

    // Full write transfer of n bytes from wbuf, checked against the model.
    task automatic do_write(input logic [7:0] sub, input int n, input string req);
        bit ack, mh, trig_prev, trig;
        logic [4:0] idx;
        i2c_start();
        write_byte(8'h88, ack, mh);
        check(ack, "R1", "address ack", int'(ack), 1);
        write_byte(sub, ack, mh);
        check(ack, "R2", "subaddress ack", int'(ack), 1);
        idx = sub[4:0];
        trig_prev = 1'b0;
        m_test = sub[7];
        for (int k = 0; k < n; k++) begin
            write_byte(wbuf[k], ack, mh);
            check(ack, "R3", "data ack", int'(ack), 1);
            trig = (idx == 5'(SRC)) && !sub[6];
            check(mh == (trig || trig_prev), trig ? "R5" : "R6/R11",
                  "mute during ack", int'(mh), int'(trig || trig_prev));
            if (int'(idx) < NREG) model[idx] = wbuf[k];
            if (sub[5]) idx = idx + 5'd1;
            trig_prev = trig;
        end
        i2c_stop();
        tick(4);
        compare_regs(req);
        check(test_mode == (m_test && model[TST][0]), "R8", "test mode",
              int'(test_mode), int'(m_test && model[TST][0]));
        tick(AZC + 60);
    endtask

    int b0, r0, o0;

    initial begin
        bit ack, mh;
        logic [7:0] rb;
        void'($urandom(32'h5EED));
        rst_n = 1'b0; m_scl = 1'b1; m_low = 1'b0; status = 8'h00;
        for (int i = 0; i < 32; i++) model[i] = 8'hFE;
        tick(6);
        rst_n = 1'b1;
        tick(6);

        // R9: reset state
        compare_regs("R9");
        check(!sda_oe && !az_busy && !mute_hold && !test_mode, "R9",
              "outputs after reset", {sda_oe, az_busy, mute_hold, test_mode}, 0);

        // R3: single byte, auto-increment set
        wbuf[0] = 8'h5A; do_write(8'h23, 1, "R3");
        // R4: auto-increment across three registers
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; do_write(8'h25, 3, "R4");
        // R4: no auto-increment, last byte wins
        wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3; do_write(8'h07, 3, "R4");

        // R5: single source write, exact window
        b0 = busy_cyc; r0 = busy_rise;
        wbuf[0] = 8'h03; do_write(8'h00, 1, "R5");
        check(busy_cyc - b0 == AZC, "R5", "busy length", busy_cyc - b0, AZC);
        check(busy_rise - r0 == 1, "R5", "busy pulses", busy_rise - r0, 1);

        // R6: keep-alignment suppresses the window
        b0 = busy_cyc;
        wbuf[0] = 8'h02; do_write(8'h40, 1, "R6");
        check(busy_cyc - b0 == 0, "R6", "busy length", busy_cyc - b0, 0);

        // R10: two source writes one byte apart retrigger the window
        b0 = busy_cyc; r0 = busy_rise;
        wbuf[0] = 8'h01; wbuf[1] = 8'h00; do_write(8'h00, 2, "R10");
        check(busy_cyc - b0 == 288 + AZC, "R10", "busy length", busy_cyc - b0, 288 + AZC);
        check(busy_rise - r0 == 1, "R10", "busy pulses", busy_rise - r0, 1);

        // R11: other registers never trigger
        b0 = busy_cyc;
        wbuf[0] = 8'h77; wbuf[1] = 8'h66; do_write(8'h21, 2, "R11");
        check(busy_cyc - b0 == 0, "R11", "busy length", busy_cyc - b0, 0);

        // R3: index beyond the bank is dropped but acknowledged
        wbuf[0] = 8'h99; do_write(8'h14, 1, "R3");

        // R4 + R5: wrap from index 31 to the source register
        b0 = busy_cyc;
        wbuf[0] = 8'h44; wbuf[1] = 8'h05; do_write(8'h3F, 2, "R4");
        check(busy_cyc - b0 == AZC, "R5", "busy after wrap", busy_cyc - b0, AZC);

        // R8: test-mode combinations
        wbuf[0] = 8'h01; do_write(8'h80 | 8'(TST), 1, "R8");
        wbuf[0] = 8'h10; do_write(8'h03, 1, "R8");
        wbuf[0] = 8'h20; do_write(8'h83, 1, "R8");
        wbuf[0] = 8'h00; do_write(8'h80 | 8'(TST), 1, "R8");

        // R7: read three status bytes, changing between bytes, then NACK
        status = 8'hA5;
        i2c_start();
        write_byte(8'h89, ack, mh);
        check(ack, "R1", "read address ack", int'(ack), 1);
        read_byte(1'b0, 8'h3C, rb);
        check(rb == 8'hA5, "R7", "status byte 0", rb, 8'hA5);
        read_byte(1'b0, 8'h01, rb);
        check(rb == 8'h3C, "R7", "status byte 1", rb, 8'h3C);
        o0 = oe_cyc;
        read_byte(1'b1, 8'hFF, rb);
        check(rb == 8'h01, "R7", "status byte 2 soft-mute bit", rb, 8'h01);
        o0 = oe_cyc;
        tick(3*Q);
        i2c_stop();
        check(oe_cyc - o0 == 0, "R7", "released after nack", oe_cyc - o0, 0);
        tick(20);

        // R1: foreign address, no drive at all, registers untouched
        o0 = oe_cyc;
        i2c_start();
        write_byte(8'h90, ack, mh);
        check(!ack, "R1", "foreign address nack", int'(ack), 0);
        write_byte(8'h23, ack, mh);
        write_byte(8'hEE, ack, mh);
        i2c_stop();
        tick(4);
        check(oe_cyc - o0 == 0, "R1", "no drive on mismatch", oe_cyc - o0, 0);
        compare_regs("R1");
        tick(AZC + 60);

        // Random transfers against the model (R2, R3, R4, R5, R6, R11)
        for (int t = 0; t < 30; t++) begin
            logic [7:0] sub;
            int n;
            sub = {$urandom_range(1, 0) == 1, $urandom_range(1, 0) == 1,
                   $urandom_range(1, 0) == 1, 5'($urandom_range(19, 0))};
            n = $urandom_range(4, 1);
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom_range(255, 0));
            do_write(sub, n, "R2");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule